// File: doc/BRIEF.md
# Serial Controller FIFO Status and Interrupt Unit

This unit collects the status of a serial controller's input and output word FIFOs and turns it into one level interrupt. The data path pulses event strobes when a FIFO wants service, when a whole block can be moved, when a word has been transferred and when an error occurs. The unit records each event in a sticky flag, counts transferred words per direction against a programmed limit, and raises the interrupt while any unmasked service flag, any done flag or any enabled error flag is pending. Software acknowledges each flag by writing a one to its bit. Writing a zero to a bit leaves it unchanged.

Two transfer styles are supported. In FIFO mode each direction is limited by a FIFO-mode count register. In block mode, which also covers DMA transfers, each direction uses a separate block-mode count register. During DMA transfers a mask register keeps the service flags from reaching the interrupt, while the flags themselves are still recorded. The FIFO storage and the serial shifter are outside this unit.

Top module: `sio_status_irq`

## Requirements
- R1: After reset every register reads zero: flags, mask, enables, mode and all four count limits. The interrupt is low.
- R2: Reads of the operations register (address 0) return the live FIFO levels with no delay. Bit 4 is output not empty, bit 5 is input not empty, bit 6 is output full and bit 7 is input full.
- R3: In the operations register, bit 8 (output service), bit 9 (input service), bit 12 (output block request) and bit 13 (input block request) are set by their event strobes and cleared by writing a one to the bit. An event in the same cycle as the clear wins, so the flag stays set.
- R4: Writing zero bits to a flag register has no effect on the flags.
- R5: Controller error flags (address 2) are bit 2 input overrun, bit 3 output underrun, bit 4 input underrun and bit 5 output overrun. Serial error flags (address 4) are bit 0 clock underrun and bit 1 clock overrun. Each is set by its strobe and cleared by writing a one to it.
- R6: The interrupt is the OR of the unmasked service flags, the done flags (bit 10 output, bit 11 input) and the enabled error flags. The block request flags do not drive the interrupt.
- R7: The mask register (address 1) uses bit 8 for output service and bit 9 for input service. A set mask bit keeps that service flag out of the interrupt, but the flag is still recorded.
- R8: The mode register (address 6) bit 0 selects the limits. With bit 0 at 0 (FIFO mode), the input limit is at address 7 and the output limit at address 8. With bit 0 at 1 (block mode), the input limit is at address 9 and the output limit at address 10. The limits of the mode not selected have no effect.
- R9: A direction's done flag sets on the word strobe that brings its count equal to a nonzero limit. A limit of zero never sets the done flag.
- R10: Writing either count limit of a direction restarts that direction's word count from zero. Writing the mode register restarts both directions.
- R11: The error enables (address 3 for controller errors, address 5 for serial errors, same bit positions as the flags) gate only the interrupt. Error flags are recorded whether or not they are enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| in_fifo_ne | input | 1 | Input FIFO holds data |
| out_fifo_ne | input | 1 | Output FIFO holds data |
| in_fifo_full | input | 1 | Input FIFO full |
| out_fifo_full | input | 1 | Output FIFO full |
| in_svc_ev | input | 1 | Input FIFO wants service |
| out_svc_ev | input | 1 | Output FIFO wants service |
| in_blk_ev | input | 1 | A block is ready to be read |
| out_blk_ev | input | 1 | Room for a block to be written |
| in_word_ev | input | 1 | One input word transferred |
| out_word_ev | input | 1 | One output word transferred |
| ctl_err_ev | input | 4 | Controller error strobes, in the order of bits 2 to 5 |
| ser_err_ev | input | 2 | Serial clock error strobes, in the order of bits 0 and 1 |
| irq_o | output | 1 | Level interrupt |

## Verification
An event strobe that is present at a rising edge shows up as a flag in a read at the falling edge that follows that edge. The interrupt follows the flags in the same cycle, because its OR is combinational. A register write takes effect at the edge where it is sampled. Reads add no delay, so the live FIFO level bits follow their inputs at once. The bench drives every stimulus at a falling edge and holds it for one cycle. It removes the stimulus at the next falling edge and checks the read data and the interrupt one time step later, which is exactly where each result is due.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;
   localparam int unsigned ADDR_W = 4;

   localparam logic [ADDR_W-1:0] A_OPS          = 4'd0;
   localparam logic [ADDR_W-1:0] A_OPMASK       = 4'd1;
   localparam logic [ADDR_W-1:0] A_CERR         = 4'd2;
   localparam logic [ADDR_W-1:0] A_CERR_EN      = 4'd3;
   localparam logic [ADDR_W-1:0] A_SERR         = 4'd4;
   localparam logic [ADDR_W-1:0] A_SERR_EN      = 4'd5;
   localparam logic [ADDR_W-1:0] A_MODE         = 4'd6;
   localparam logic [ADDR_W-1:0] A_FIFO_IN_LIM  = 4'd7;
   localparam logic [ADDR_W-1:0] A_FIFO_OUT_LIM = 4'd8;
   localparam logic [ADDR_W-1:0] A_BLK_IN_LIM   = 4'd9;
   localparam logic [ADDR_W-1:0] A_BLK_OUT_LIM  = 4'd10;

   // field positions decoded by software
   localparam int unsigned OPS_LVL_LSB = 4;
   localparam int unsigned OPS_STK_LSB = 8;
   localparam int unsigned OPS_STK_W   = 6;
   localparam int unsigned CERR_LSB    = 2;
   localparam int unsigned CERR_W      = 4;
   localparam int unsigned SERR_LSB    = 0;
   localparam int unsigned SERR_W      = 2;
   localparam int unsigned MASK_W      = 2;
   localparam int unsigned NUM_DIR     = 2;

   localparam int unsigned DIR_OUT = 0;
   localparam int unsigned DIR_IN  = 1;
endpackage

// File: rtl/sio_flag_w1c.sv
module sio_flag_w1c #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_width
      $error("sio_flag_w1c: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= (q_o & ~clr_i) | set_i;
   end

   // R3 / R5: a one written without a competing event clears the flag
   assert_w1c_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

   // R3 / R5: an event always leaves its flag set, even against a clear
   assert_w1c_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

   // R4: no event and no one written keeps every flag as it was
   assert_w1c_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i == '0 && set_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/sio_word_tally.sv
module sio_word_tally #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             step_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             hit_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("sio_word_tally: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_nxt;

   assign cnt_nxt = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cnt_q <= '0;
      else if (restart_i)                   cnt_q <= '0;
      else if (step_i && cnt_q != CNT_MAX)  cnt_q <= cnt_nxt[CNT_W-1:0];
   end

   assign hit_o = step_i && !restart_i && (limit_i != '0) &&
                  (cnt_nxt == {1'b0, limit_i});

   // R9: the limit is reached once, never on two cycles in a row
   assert_single_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o);

   // R10: after a restart only a limit of one can be reached at once
   assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (!hit_o || limit_i == ONE));
endmodule

// File: rtl/sio_status_irq.sv
module sio_status_irq
   import sio_stat_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 16,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              in_fifo_ne,
   input  logic              out_fifo_ne,
   input  logic              in_fifo_full,
   input  logic              out_fifo_full,
   input  logic              in_svc_ev,
   input  logic              out_svc_ev,
   input  logic              in_blk_ev,
   input  logic              out_blk_ev,
   input  logic              in_word_ev,
   input  logic              out_word_ev,
   input  logic [3:0]        ctl_err_ev,
   input  logic [1:0]        ser_err_ev,
   output logic              irq_o
);
   localparam int unsigned OPS_MSB = OPS_STK_LSB + OPS_STK_W - 1;

   if (DATA_W < OPS_MSB + 1) begin : g_bad_data
      $error("sio_status_irq: DATA_W too narrow for the operations register");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("sio_status_irq: CNT_W must lie between 1 and DATA_W");
   end

   // ---------------- register writes ----------------
   logic              wr_ops, wr_cerr, wr_serr;
   logic [MASK_W-1:0] mask_q;
   logic [CERR_W-1:0] cerr_en_q;
   logic [SERR_W-1:0] serr_en_q;
   logic              mode_blk_q;
   logic [CNT_W-1:0]  fifo_lim_q [NUM_DIR];
   logic [CNT_W-1:0]  blk_lim_q  [NUM_DIR];

   assign wr_ops  = reg_we && reg_addr == A_OPS;
   assign wr_cerr = reg_we && reg_addr == A_CERR;
   assign wr_serr = reg_we && reg_addr == A_SERR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q     <= '0;
         cerr_en_q  <= '0;
         serr_en_q  <= '0;
         mode_blk_q <= 1'b0;
      end else if (reg_we) begin
         case (reg_addr)
            A_OPMASK:  mask_q     <= reg_wdata[OPS_STK_LSB +: MASK_W];
            A_CERR_EN: cerr_en_q  <= reg_wdata[CERR_LSB +: CERR_W];
            A_SERR_EN: serr_en_q  <= reg_wdata[SERR_LSB +: SERR_W];
            A_MODE:    mode_blk_q <= reg_wdata[0];
            default: ;
         endcase
      end
   end

   // ---------------- per-direction word counting ----------------
   logic [NUM_DIR-1:0] word_ev, hit;

   assign word_ev[DIR_OUT] = out_word_ev;
   assign word_ev[DIR_IN]  = in_word_ev;

   for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      localparam logic [3:0] FIFO_A = (d == DIR_IN) ? A_FIFO_IN_LIM : A_FIFO_OUT_LIM;
      localparam logic [3:0] BLK_A  = (d == DIR_IN) ? A_BLK_IN_LIM  : A_BLK_OUT_LIM;

      logic             restart;
      logic [CNT_W-1:0] limit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fifo_lim_q[d] <= '0;
            blk_lim_q[d]  <= '0;
         end else if (reg_we) begin
            if (reg_addr == FIFO_A) fifo_lim_q[d] <= reg_wdata[CNT_W-1:0];
            if (reg_addr == BLK_A)  blk_lim_q[d]  <= reg_wdata[CNT_W-1:0];
         end
      end

      assign restart = reg_we && (reg_addr == FIFO_A || reg_addr == BLK_A ||
                                  reg_addr == A_MODE);
      assign limit   = mode_blk_q ? blk_lim_q[d] : fifo_lim_q[d];

      sio_word_tally #(.CNT_W(CNT_W)) u_tally (
         .clk       (clk),
         .rst_n     (rst_n),
         .restart_i (restart),
         .step_i    (word_ev[d]),
         .limit_i   (limit),
         .hit_o     (hit[d])
      );
   end

   // ---------------- sticky flag banks ----------------
   // ops bank bit k maps to operations register bit OPS_STK_LSB + k:
   // 0 out service, 1 in service, 2 out done, 3 in done, 4 out block, 5 in block
   logic [OPS_STK_W-1:0] ops_set, ops_clr, ops_q;
   logic [CERR_W-1:0]    cerr_q;
   logic [SERR_W-1:0]    serr_q;

   assign ops_set = {in_blk_ev, out_blk_ev, hit[DIR_IN], hit[DIR_OUT],
                     in_svc_ev, out_svc_ev};
   assign ops_clr = wr_ops ? reg_wdata[OPS_STK_LSB +: OPS_STK_W] : '0;

   sio_flag_w1c #(.W(OPS_STK_W)) u_ops (
      .clk (clk), .rst_n (rst_n),
      .set_i (ops_set), .clr_i (ops_clr), .q_o (ops_q)
   );

   sio_flag_w1c #(.W(CERR_W)) u_cerr (
      .clk (clk), .rst_n (rst_n),
      .set_i (ctl_err_ev),
      .clr_i (wr_cerr ? reg_wdata[CERR_LSB +: CERR_W] : '0),
      .q_o (cerr_q)
   );

   sio_flag_w1c #(.W(SERR_W)) u_serr (
      .clk (clk), .rst_n (rst_n),
      .set_i (ser_err_ev),
      .clr_i (wr_serr ? reg_wdata[SERR_LSB +: SERR_W] : '0),
      .q_o (serr_q)
   );

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_OPS: begin
            reg_rdata[OPS_LVL_LSB +: 4] = {in_fifo_full, out_fifo_full,
                                           in_fifo_ne, out_fifo_ne};
            reg_rdata[OPS_STK_LSB +: OPS_STK_W] = ops_q;
         end
         A_OPMASK:       reg_rdata[OPS_STK_LSB +: MASK_W] = mask_q;
         A_CERR:         reg_rdata[CERR_LSB +: CERR_W]    = cerr_q;
         A_CERR_EN:      reg_rdata[CERR_LSB +: CERR_W]    = cerr_en_q;
         A_SERR:         reg_rdata[SERR_LSB +: SERR_W]    = serr_q;
         A_SERR_EN:      reg_rdata[SERR_LSB +: SERR_W]    = serr_en_q;
         A_MODE:         reg_rdata[0]                     = mode_blk_q;
         A_FIFO_IN_LIM:  reg_rdata[CNT_W-1:0] = fifo_lim_q[DIR_IN];
         A_FIFO_OUT_LIM: reg_rdata[CNT_W-1:0] = fifo_lim_q[DIR_OUT];
         A_BLK_IN_LIM:   reg_rdata[CNT_W-1:0] = blk_lim_q[DIR_IN];
         A_BLK_OUT_LIM:  reg_rdata[CNT_W-1:0] = blk_lim_q[DIR_OUT];
         default: ;
      endcase
   end

   // ---------------- interrupt ----------------
   logic irq_src;

   assign irq_src = (|(ops_q[1:0] & ~mask_q)) | (|ops_q[3:2]) |
                    (|(cerr_q & cerr_en_q)) | (|(serr_q & serr_en_q));

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_src;
      end
      assign irq_o = irq_q;

      // R6: an unmasked input service event reaches the pin two edges later
      assert_svc_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (in_svc_ev && !mask_q[1]) |-> ##2 irq_o);
   end else begin : g_irq_comb
      assign irq_o = irq_src;

      // R6: an unmasked input service event raises the interrupt next cycle
      assert_svc_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (in_svc_ev && !mask_q[1]) |=> irq_o);

      // R9: a reached input limit raises the interrupt next cycle
      assert_done_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
         hit[DIR_IN] |=> irq_o);
   end
endmodule

// File: tb/sio_status_irq_test.sv
module sio_status_irq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        in_fifo_ne = 1'b0, out_fifo_ne = 1'b0;
   logic        in_fifo_full = 1'b0, out_fifo_full = 1'b0;
   logic        in_svc_ev = 1'b0, out_svc_ev = 1'b0;
   logic        in_blk_ev = 1'b0, out_blk_ev = 1'b0;
   logic        in_word_ev = 1'b0, out_word_ev = 1'b0;
   logic [3:0]  ctl_err_ev = '0;
   logic [1:0]  ser_err_ev = '0;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sio_status_irq uut (
      .clk (clk), .rst_n (rst_n),
      .reg_we (reg_we), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .in_fifo_ne (in_fifo_ne), .out_fifo_ne (out_fifo_ne),
      .in_fifo_full (in_fifo_full), .out_fifo_full (out_fifo_full),
      .in_svc_ev (in_svc_ev), .out_svc_ev (out_svc_ev),
      .in_blk_ev (in_blk_ev), .out_blk_ev (out_blk_ev),
      .in_word_ev (in_word_ev), .out_word_ev (out_word_ev),
      .ctl_err_ev (ctl_err_ev), .ser_err_ev (ser_err_ev),
      .irq_o (irq_o)
   );

   // ev bits: 0 in svc, 1 out svc, 2 in block, 3 out block, 4 in word, 5 out word
   typedef struct packed {
      logic        we;
      logic [3:0]  addr;
      logic [15:0] wdata;
      logic [5:0]  ev;
      logic [3:0]  raddr;
      logic [15:0] exp;
      logic        exp_irq;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 4'd0,  16'h0000, 6'b000001, 4'd0,  16'h0200, 1'b1}, // R3 set
      '{1'b1, 4'd0,  16'h0200, 6'b000000, 4'd0,  16'h0000, 1'b0}, // R3 clear
      '{1'b0, 4'd0,  16'h0000, 6'b001000, 4'd0,  16'h1000, 1'b0}, // R6 block req no irq
      '{1'b1, 4'd0,  16'h0000, 6'b000000, 4'd0,  16'h1000, 1'b0}, // R4 zeros
      '{1'b1, 4'd0,  16'h1000, 6'b000000, 4'd0,  16'h0000, 1'b0}, // R3
      '{1'b1, 4'd1,  16'h0300, 6'b000000, 4'd1,  16'h0300, 1'b0}, // R7 mask
      '{1'b0, 4'd0,  16'h0000, 6'b000010, 4'd0,  16'h0100, 1'b0}, // R7 masked
      '{1'b1, 4'd0,  16'h0100, 6'b000000, 4'd0,  16'h0000, 1'b0}, // R3
      '{1'b1, 4'd7,  16'h0003, 6'b000000, 4'd7,  16'h0003, 1'b0}, // R8 fifo in lim
      '{1'b0, 4'd0,  16'h0000, 6'b010000, 4'd0,  16'h0000, 1'b0}, // R9 1 of 3
      '{1'b0, 4'd0,  16'h0000, 6'b010000, 4'd0,  16'h0000, 1'b0}, // R9 2 of 3
      '{1'b0, 4'd0,  16'h0000, 6'b010000, 4'd0,  16'h0800, 1'b1}, // R9 done
      '{1'b1, 4'd0,  16'h0800, 6'b000000, 4'd0,  16'h0000, 1'b0}, // R9 clear
      '{1'b1, 4'd9,  16'h0001, 6'b000000, 4'd9,  16'h0001, 1'b0}, // R8 blk in lim
      '{1'b0, 4'd0,  16'h0000, 6'b010000, 4'd0,  16'h0000, 1'b0}, // R8 unused limit
      '{1'b1, 4'd6,  16'h0001, 6'b000000, 4'd6,  16'h0001, 1'b0}, // R8 block mode
      '{1'b0, 4'd0,  16'h0000, 6'b010000, 4'd0,  16'h0800, 1'b1}, // R8 blk limit used
      '{1'b1, 4'd0,  16'h0800, 6'b000000, 4'd0,  16'h0000, 1'b0}, // R3
      '{1'b0, 4'd0,  16'h0000, 6'b100000, 4'd0,  16'h0000, 1'b0}, // R9 zero limit
      '{1'b0, 4'd0,  16'h0000, 6'b100000, 4'd0,  16'h0000, 1'b0}, // R9 zero limit
      '{1'b1, 4'd10, 16'h0002, 6'b000000, 4'd10, 16'h0002, 1'b0}, // R10 set lim
      '{1'b0, 4'd0,  16'h0000, 6'b100000, 4'd0,  16'h0000, 1'b0}, // R10 1 of 2
      '{1'b1, 4'd10, 16'h0002, 6'b000000, 4'd10, 16'h0002, 1'b0}, // R10 restart
      '{1'b0, 4'd0,  16'h0000, 6'b100000, 4'd0,  16'h0000, 1'b0}, // R10 1 again
      '{1'b0, 4'd0,  16'h0000, 6'b100000, 4'd0,  16'h0400, 1'b1}, // R10 done
      '{1'b1, 4'd0,  16'h0400, 6'b000000, 4'd0,  16'h0000, 1'b0}, // R3
      '{1'b0, 4'd0,  16'h0000, 6'b000001, 4'd0,  16'h0200, 1'b0}, // R7 in masked
      '{1'b1, 4'd0,  16'h0200, 6'b000000, 4'd0,  16'h0000, 1'b0}, // R3
      '{1'b1, 4'd1,  16'h0000, 6'b000000, 4'd1,  16'h0000, 1'b0}  // R7 unmask
   };
   localparam string VTAG [NV] = '{
      "R3", "R3", "R6", "R4", "R3", "R7", "R7", "R3", "R8", "R9",
      "R9", "R9", "R9", "R8", "R8", "R8", "R8", "R3", "R9", "R9",
      "R10", "R10", "R10", "R10", "R10", "R3", "R7", "R3", "R7"
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state of every register and the interrupt
      for (int a = 0; a <= 10; a++) rd_chk("R1", 4'(a), 32'h0);
      chk("R1 irq", {31'b0, irq_o}, 32'h0);

      // R2: live FIFO levels
      in_fifo_ne = 1'b1; out_fifo_full = 1'b1;
      rd_chk("R2", 4'd0, 32'h0000_0060);
      in_fifo_ne = 1'b0; out_fifo_full = 1'b0; out_fifo_ne = 1'b1; in_fifo_full = 1'b1;
      rd_chk("R2", 4'd0, 32'h0000_0090);
      out_fifo_ne = 1'b0; in_fifo_full = 1'b0;

      // vector table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         reg_we = VECS[i].we; reg_addr = VECS[i].addr;
         reg_wdata = {16'h0, VECS[i].wdata};
         {out_word_ev, in_word_ev, out_blk_ev, in_blk_ev, out_svc_ev, in_svc_ev} = VECS[i].ev;
         @(negedge clk);
         reg_we = 1'b0; reg_wdata = '0;
         {out_word_ev, in_word_ev, out_blk_ev, in_blk_ev, out_svc_ev, in_svc_ev} = '0;
         rd_chk(VECS[i].exp === VECS[i].exp ? VTAG[i] : "", VECS[i].raddr, {16'h0, VECS[i].exp});
         chk({VTAG[i], " irq"}, {31'b0, irq_o}, {31'b0, VECS[i].exp_irq});
      end

      // R5 / R11: controller errors recorded without enable, gated irq
      @(negedge clk); ctl_err_ev = 4'b0001;
      @(negedge clk); ctl_err_ev = '0;
      rd_chk("R5", 4'd2, 32'h0000_0004);
      chk("R11 irq off", {31'b0, irq_o}, 32'h0);
      wr(4'd3, 32'h0000_0004);
      #1 chk("R11 irq on", {31'b0, irq_o}, 32'h1);
      @(negedge clk); ctl_err_ev = 4'b1110;
      @(negedge clk); ctl_err_ev = '0;
      rd_chk("R5", 4'd2, 32'h0000_003C);
      wr(4'd2, 32'h0000_0004);
      rd_chk("R5", 4'd2, 32'h0000_0038);
      chk("R11 irq off", {31'b0, irq_o}, 32'h0);
      wr(4'd2, 32'h0000_0038);
      rd_chk("R5", 4'd2, 32'h0);

      // R5 / R11: serial errors
      @(negedge clk); ser_err_ev = 2'b10;
      @(negedge clk); ser_err_ev = '0;
      rd_chk("R5", 4'd4, 32'h0000_0002);
      chk("R11 irq off", {31'b0, irq_o}, 32'h0);
      wr(4'd5, 32'h0000_0002);
      #1 chk("R11 irq on", {31'b0, irq_o}, 32'h1);
      wr(4'd4, 32'h0000_0002);
      rd_chk("R5", 4'd4, 32'h0);
      chk("R6 irq low", {31'b0, irq_o}, 32'h0);

      // R3: event beats a clear in the same cycle
      @(negedge clk);
      in_svc_ev = 1'b1; reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h0000_0200;
      @(negedge clk);
      in_svc_ev = 1'b0; reg_we = 1'b0; reg_wdata = '0;
      rd_chk("R3", 4'd0, 32'h0000_0200);
      chk("R6 irq", {31'b0, irq_o}, 32'h1);
      wr(4'd0, 32'h0000_0200);
      rd_chk("R3", 4'd0, 32'h0);
      chk("R6 irq", {31'b0, irq_o}, 32'h0);

      finish_run();
   end
endmodule